// File: doc/BRIEF.md
# MDIO Management Transaction Controller

This block gives a host a simple way to read and write registers in an Ethernet PHY over the two-wire management interface (MDC clock plus bidirectional MDIO data). The host sees two 16-bit registers: a command register and a data register. Writing the command register while the controller is idle launches one clause-22 management frame. For a write, the data register supplies the 16 bits that are sent. For a read, the 16 bits returned by the PHY land in the data register when the frame ends.

MDC is made from the system clock by a parameterised divider and runs only while a frame is in flight. MDIO is driven as a separate output and output-enable, so an I/O cell or a board-level tristate can be placed outside the block. A completion flag in the command register reads as set when the controller is idle. It drops while a frame is active, and the host polls it before starting the next command.

Top module: `mdio_xact_ctrl`

## Requirements
- R1: After reset, ctrl_rd reads 16'h8000 (done set, all fields zero), data_rd is 0, mdc is 0, mdio_oe is 0 and mdio_o is 1.
- R2: A register write with reg_sel=0 is a command write. In the command word, the PHY register number is bits 4:0, the PHY address is bits 12:8, bit 13 set selects a write and bit 13 clear selects a read. When the command is accepted, ctrl_rd shows these three fields in the same positions and shows bits 14 and 7:5 as zero.
- R3: ctrl_rd bit 15 (done) reads 0 on the cycle after a command is accepted. It reads 1 again exactly (PRE_LEN+32)*2*DIV_HALF cycles after the accepting clock edge.
- R4: While a frame is active, mdc has a period of 2*DIV_HALF system clocks and is high for DIV_HALF of them.
- R5: The frame is sent MSB first. Its fields are PRE_LEN ones, start bits 01, opcode 10 for a read or 01 for a write, the 5-bit PHY address, the 5-bit register number, two turnaround bits and 16 data bits.
- R6: On a write, mdio_oe stays high for the whole frame, the turnaround is sent as 10 and the data field equals data_rd as it stood when the command was accepted.
- R7: On a read, mdio_oe drops at the first turnaround bit and stays low to the end of the frame. The 16 data bits are sampled from mdio_i on the rising edges of mdc, MSB first, and appear on data_rd in the same cycle that done returns to 1.
- R8: mdio_o changes value only in the cycle in which mdc falls.
- R9: While a frame is active, command writes and data writes (reg_sel=1) are ignored. The running frame, ctrl_rd and data_rd are left unchanged by them.
- R10: A data write while idle sets data_rd to reg_wdata on the next cycle.
- R11: While idle, mdc is 0, mdio_oe is 0 and mdio_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the command register, 1 selects the data register |
| reg_wdata | input | 16 | Write data |
| ctrl_rd | output | 16 | Command register readback with the done flag at bit 15 |
| data_rd | output | 16 | Data register readback |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data input from the pad |
| mdio_o | output | 1 | Management data output to the pad |
| mdio_oe | output | 1 | Output enable for the management data pad |

## Verification
The hardest behaviour to reach from the ports is a host write that arrives in the middle of an active frame. A well-behaved host never issues one, and its effect only shows up in the bits that follow. The bench therefore waits half a frame after some commands, then fires both a conflicting command write and a data write. It then checks that the bits sent afterwards, the command readback and the data register all still match the original command. A small PHY model on the bench's MDC edges captures every driven bit and supplies read data on falling edges. Each frame is checked against a frame built by a bench function for randomised addresses, register numbers and data.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CMD_W       = 16;
  localparam int FLD_W       = 5;
  localparam int DONE_BIT    = 15;
  localparam int WRSEL_BIT   = 13;
  localparam int PHY_LSB     = 8;
  localparam int REGN_LSB    = 0;
  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] TA_DRIVEN  = 2'b10;

  typedef struct packed {
    logic             wr;
    logic [FLD_W-1:0] phy;
    logic [FLD_W-1:0] regn;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick     = run && (cnt == LAST);
  assign rise_stb = tick && !mdc;
  assign fall_stb = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick) mdc <= ~mdc;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic [15:0] wdata,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        rd_valid,
  output logic [15:0] rd_data
);
  localparam int FRAME_W = PRE_LEN + 32;
  localparam int CW      = $clog2(FRAME_W);
  localparam logic [CW-1:0] TA_IDX  = CW'(PRE_LEN + 14);
  localparam logic [CW-1:0] DAT_IDX = CW'(PRE_LEN + 16);
  localparam logic [CW-1:0] END_IDX = CW'(FRAME_W - 1);

  logic [FRAME_W-1:0] sr;
  logic [CW-1:0]      idx;
  logic               is_wr;
  logic [15:0]        cap;
  logic               last_fall;

  function automatic logic [FRAME_W-1:0] build_frame(mdio_cmd_t c, logic [15:0] d);
    return {{PRE_LEN{1'b1}}, START_CODE, (c.wr ? OP_WRITE : OP_READ),
            c.phy, c.regn, (c.wr ? TA_DRIVEN : 2'b11), (c.wr ? d : 16'hFFFF)};
  endfunction

  assign mdio_o    = sr[FRAME_W-1];
  assign last_fall = busy && fall_stb && (idx == END_IDX);
  assign rd_valid  = last_fall && !is_wr;
  assign rd_data   = cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sr      <= '1;
      idx     <= '0;
      is_wr   <= 1'b0;
      mdio_oe <= 1'b0;
      cap     <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        sr      <= build_frame(cmd, wdata);
        idx     <= '0;
        is_wr   <= cmd.wr;
        mdio_oe <= 1'b1;
      end
    end else begin
      if (rise_stb && !is_wr && (idx >= DAT_IDX))
        cap <= {cap[14:0], mdio_i};
      if (last_fall) begin
        busy    <= 1'b0;
        mdio_oe <= 1'b0;
        sr      <= '1;
        idx     <= '0;
      end else if (fall_stb) begin
        idx <= idx + 1'b1;
        sr  <= {sr[FRAME_W-2:0], 1'b1};
        if (!is_wr && (idx + 1'b1 == TA_IDX))
          mdio_oe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdio_xact_ctrl.sv
module mdio_xact_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] ctrl_rd,
  output logic [15:0] data_rd,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic        busy, start, rise_stb, fall_stb, rd_valid;
  logic [15:0] rd_data;
  mdio_cmd_t   new_cmd, cmd_q;
  logic [15:0] data_q;

  assign start        = reg_wr && !reg_sel && !busy;
  assign new_cmd.wr   = reg_wdata[WRSEL_BIT];
  assign new_cmd.phy  = reg_wdata[PHY_LSB +: FLD_W];
  assign new_cmd.regn = reg_wdata[REGN_LSB +: FLD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (start) cmd_q <= new_cmd;
      if (rd_valid)
        data_q <= rd_data;
      else if (reg_wr && reg_sel && !busy)
        data_q <= reg_wdata;
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[DONE_BIT]              = !busy;
    ctrl_rd[WRSEL_BIT]             = cmd_q.wr;
    ctrl_rd[PHY_LSB +: FLD_W]      = cmd_q.phy;
    ctrl_rd[REGN_LSB +: FLD_W]     = cmd_q.regn;
  end
  assign data_rd = data_q;

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst(rst), .run(busy),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk(clk), .rst(rst), .start(start), .cmd(new_cmd), .wdata(data_q),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/mdio_xact_ctrl_chk.sv
module mdio_xact_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr,
  input logic        reg_sel,
  input logic [15:0] reg_wdata,
  input logic [15:0] ctrl_rd,
  input logic [15:0] data_rd,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  a_r3_done_clears: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_sel && ctrl_rd[15]) |=> !ctrl_rd[15]);

  a_r9_cmd_ignored: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_sel && !ctrl_rd[15]) |=> $stable(ctrl_rd[14:0]));

  a_r9_data_ignored: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel && !ctrl_rd[15]) |=> ($stable(data_rd) || ctrl_rd[15]));

  a_r10_data_write: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel && ctrl_rd[15]) |=> (data_rd == $past(reg_wdata)));

  a_r8_mdio_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> $fell(mdc));

  a_r11_idle_pins: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd[15] |-> (!mdc && !mdio_oe && mdio_o));
endmodule

bind mdio_xact_ctrl mdio_xact_ctrl_chk u_chk (.*);

// File: tb/mdio_xact_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_xact_ctrl_tb_top;
  localparam int DH      = 4;
  localparam int PRE     = 32;
  localparam int FW      = PRE + 32;
  localparam int TA_BIT  = PRE + 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] ctrl_rd, data_rd;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int unsigned checks = 0, fails = 0, cyc = 0;
  int unsigned rise_total = 0, base = 0, gap_bad = 0;
  logic [15:0] phy_val = '0;
  logic        phy_rd = 1'b0;
  logic [FW-1:0] cap_bits = '0, cap_oe = '0;
  time last_rise = 0;

  mdio_xact_ctrl #(.DIV_HALF(DH), .PRE_LEN(PRE)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_rd(ctrl_rd), .data_rd(data_rd),
    .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // PHY model: capture on rising MDC, answer on falling MDC
  always @(posedge mdc) begin
    int r;
    r = int'(rise_total - base);
    if (r > 0 && ($time - last_rise) != time'(2 * DH * 4)) gap_bad = gap_bad + 1;
    last_rise = $time;
    if (r >= 0 && r < FW) begin
      cap_bits[FW-1-r] = mdio_o;
      cap_oe[FW-1-r]   = mdio_oe;
    end
    rise_total = rise_total + 1;
  end

  always @(negedge mdc) begin
    int r;
    r = int'(rise_total - base);
    if (phy_rd && r == TA_BIT + 1) mdio_i = 1'b0;
    else if (phy_rd && r >= TA_BIT + 2 && r < FW) mdio_i = phy_val[FW-1-r];
    else mdio_i = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] exp_frame(bit wr, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
    return {{PRE{1'b1}}, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0)};
  endfunction

  function automatic logic [FW-1:0] exp_oe(bit wr);
    return wr ? {FW{1'b1}} : {{TA_BIT{1'b1}}, {(FW-TA_BIT){1'b0}}};
  endfunction

  task automatic reg_write(input bit sel, input logic [15:0] v);
    reg_sel = sel; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic run_cmd(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] val, input bit poke);
    logic [15:0] exp_ctrl;
    logic [FW-1:0] mask;
    int unsigned c0, g0, n;
    if (wr) begin
      reg_write(1'b1, val);
      chk("R10 data write", 64'(data_rd), 64'(val));
    end else begin
      phy_val = val;
    end
    phy_rd = !wr;
    base = rise_total;
    g0 = gap_bad;
    cap_bits = '0; cap_oe = '0;
    // junk in bits 15:14 and 7:5 must not show in readback
    reg_write(1'b0, {2'b11, wr, phy, 3'b111, rg});
    c0 = cyc;
    exp_ctrl = {2'b00, wr, phy, 3'b000, rg};
    chk("R2/R3 readback after launch", 64'(ctrl_rd), 64'(exp_ctrl));
    if (poke) begin
      repeat (FW * DH) @(negedge clk);
      reg_write(1'b0, {3'b000, ~phy, 3'b000, ~rg});
      reg_write(1'b1, ~val);
      chk("R9 cmd ignored while busy", 64'(ctrl_rd), 64'(exp_ctrl));
      if (wr) chk("R9 data ignored while busy", 64'(data_rd), 64'(val));
    end
    n = 0;
    while (!ctrl_rd[15] && n < 20000) begin
      @(negedge clk); n++;
    end
    chk("R3 frame duration", 64'(cyc - c0), 64'(FW * 2 * DH));
    chk("R4 mdc period", 64'(gap_bad - g0), 64'd0);
    mask = wr ? {FW{1'b1}} : {{TA_BIT{1'b1}}, {(FW-TA_BIT){1'b0}}};
    chk(wr ? "R5/R6 write frame bits" : "R5 read frame bits",
        64'(cap_bits & mask), 64'(exp_frame(wr, phy, rg, val) & mask));
    chk(wr ? "R6 oe over write frame" : "R7 oe released at turnaround",
        64'(cap_oe), 64'(exp_oe(wr)));
    if (!wr) chk("R7 read data captured", 64'(data_rd), 64'(val));
    chk("R11 idle pins", 64'({mdc, mdio_oe, mdio_o}), 64'(3'b001));
    @(negedge clk);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd2024);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset ctrl", 64'(ctrl_rd), 64'h8000);
    chk("R1 reset data", 64'(data_rd), 64'h0);
    chk("R1 reset pins", 64'({mdc, mdio_oe, mdio_o}), 64'(3'b001));
    reg_write(1'b1, 16'h1234);
    chk("R10 idle data write", 64'(data_rd), 64'h1234);
    // directed corners
    run_cmd(1'b1, 5'h15, 5'h0A, 16'hA5C3, 1'b1);
    run_cmd(1'b0, 5'h1F, 5'h1F, 16'h8001, 1'b1);
    run_cmd(1'b0, 5'h00, 5'h00, 16'hFFFF, 1'b0);
    run_cmd(1'b1, 5'h00, 5'h00, 16'h0000, 1'b0);
    // constrained random
    for (int i = 0; i < 10; i++) begin
      run_cmd(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), (i % 3) == 0);
    end
    finish_up();
  end
endmodule